// File: doc/BRIEF.md
# Actuator End-Stop and Tray Obstruction Detector

This block decides whether a driven mechanism has come to rest against its mechanical limit. It compares a digitized back-EMF (or load-current) magnitude against a selectable level. When the magnitude is under the level, the motor is taken to be stalled and a sticky flag is raised. The flag drops again once the magnitude climbs above the level. One comparison path serves three uses. These are the sled end position, the stepping actuator end position, and obstruction detection on the tray load motor.

Sampling is armed by a zero-crossing event from the sled drive. Samples that arrive before that event are ignored. For the sled and stepping targets, a 2-bit field picks one of four evenly spaced levels. For the tray targets, a 3-bit field picks a current level between 100 and 400 in steps of 50, with the sample taken in 1 mA units. Turning the block off, or moving to another target, clears the flag and the arming. A later zero-crossing is then needed before any new sample can count.

Top module: `endstop_detect`

## Requirements
- R1: After synchronous reset, `stall_flag` is 0 and the block is not armed.
- R2: While `det_en` is 0, `stall_flag` is forced to 0 on the next edge, the arming is dropped, and samples have no effect. After `det_en` returns to 1, a new zero-crossing is needed before a sample counts.
- R3: A `zc_pulse` seen while enabled arms the block from the next cycle. A valid sample taken while the block is not armed leaves `stall_flag` unchanged.
- R4: An armed, enabled valid sample strictly below the selected level sets `stall_flag` to 1 on the clock edge that takes the sample.
- R5: An armed, enabled valid sample strictly above the level clears `stall_flag` on that same edge. A sample equal to the level leaves the flag unchanged.
- R6: When `target` is 2'b00 (sled) or 2'b01 (stepper), the level is END_STEP*(k+1), where k is `end_lvl` (0 to 3). With the defaults this gives 64, 128, 192 or 256.
- R7: When `target` is 2'b10 or 2'b11 (tray), the level is 100+50*c for `lock_lvl` code c from 0 to 6. Code 7 saturates at 400.
- R8: Any change of `target` clears `stall_flag` and the arming on the next edge. A zero-crossing in that same cycle does not arm the block.
- R9: If a valid sample and `zc_pulse` arrive together while the block is not armed, that sample is not compared. Only later samples are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_en | input | 1 | Detection enable |
| target | input | 2 | 00 sled, 01 stepper, 10/11 tray obstruction |
| end_lvl | input | 2 | End-stop level select |
| lock_lvl | input | 3 | Tray current level select |
| bemf_mag | input | SAMPLE_W | Digitized back-EMF or current magnitude |
| bemf_vld | input | 1 | Sample strobe |
| zc_pulse | input | 1 | Sled drive zero-crossing event |
| stall_flag | output | 1 | Sticky end-stop / obstruction flag |

## Verification
Each level is probed with samples at one count below and one count above it, for every end-stop code and every tray code. This separates the level tables from off-by-one comparator errors, and the saturated tray code is also probed at 420. Samples equal to the level are sent after both set and clear, to show that equality holds the flag. Low samples are sent before arming, while disabled, right after a target change, and in the same cycle as a zero-crossing. These patterns tell correct arming apart from designs that compare unconditionally or arm too early.

// File: rtl/endstop_pkg.sv
package endstop_pkg;

    typedef enum logic [1:0] {
        TGT_SLED   = 2'b00,
        TGT_STEP   = 2'b01,
        TGT_TRAY_A = 2'b10,
        TGT_TRAY_B = 2'b11
    } target_e;

    typedef struct packed {
        logic armed;
        logic tgt_chg;
    } arm_state_t;

    function automatic int unsigned end_level(input logic [1:0] sel,
                                              input int unsigned step);
        return step * (int'(sel) + 1);
    endfunction

    function automatic int unsigned lock_level(input logic [2:0] code,
                                               input int unsigned base,
                                               input int unsigned inc,
                                               input int unsigned max);
        int unsigned v;
        v = base + inc * int'(code);
        return (v > max) ? max : v;
    endfunction

    function automatic logic is_tray(input target_e t);
        return (t == TGT_TRAY_A) || (t == TGT_TRAY_B);
    endfunction

endpackage

// File: rtl/endstop_level.sv
module endstop_level
    import endstop_pkg::*;
#(
    parameter int SAMPLE_W  = 10,
    parameter int END_STEP  = 64,
    parameter int LOCK_BASE = 100,
    parameter int LOCK_INC  = 50,
    parameter int LOCK_MAX  = 400
) (
    input  logic                clk,
    input  logic                rst,
    input  target_e             target,
    input  logic [1:0]          end_lvl,
    input  logic [2:0]          lock_lvl,
    output logic [SAMPLE_W-1:0] level
);
    logic [SAMPLE_W-1:0] end_val;
    logic [SAMPLE_W-1:0] lock_val;

    always_comb begin
        end_val  = SAMPLE_W'(end_level(end_lvl, END_STEP));
        lock_val = SAMPLE_W'(lock_level(lock_lvl, LOCK_BASE, LOCK_INC, LOCK_MAX));
        level    = is_tray(target) ? lock_val : end_val;
    end

    // R7: tray level always inside the programmable span
    always_ff @(posedge clk) begin
        if (!rst && is_tray(target)) begin
            a_lock_range_r7: assert (int'(level) >= LOCK_BASE && int'(level) <= LOCK_MAX)
                else $error("tray level out of span");
        end
    end
endmodule

// File: rtl/endstop_arm.sv
module endstop_arm
    import endstop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       det_en,
    input  target_e    target,
    input  logic       zc_pulse,
    output arm_state_t st
);
    target_e prev_tgt;
    logic    armed_q;
    logic    chg;

    assign chg = (target != prev_tgt);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_tgt <= TGT_SLED;
            armed_q  <= 1'b0;
        end else begin
            prev_tgt <= target;
            if (!det_en || chg)
                armed_q <= 1'b0;
            else if (zc_pulse)
                armed_q <= 1'b1;
        end
    end

    assign st.armed   = armed_q;
    assign st.tgt_chg = chg;

    p_arm_on_zc_r3: assert property (@(posedge clk) disable iff (rst)
        det_en && !st.tgt_chg && zc_pulse |=> st.armed);

    p_disarm_r8: assert property (@(posedge clk) disable iff (rst)
        (!det_en || st.tgt_chg) |=> !st.armed);
endmodule

// File: rtl/endstop_flag.sv
module endstop_flag
    import endstop_pkg::*;
#(
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                det_en,
    input  arm_state_t          st,
    input  logic                bemf_vld,
    input  logic [SAMPLE_W-1:0] bemf_mag,
    input  logic [SAMPLE_W-1:0] level,
    output logic                flag
);
    logic take;
    assign take = st.armed && bemf_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (!det_en || st.tgt_chg) begin
            flag <= 1'b0;
        end else if (take) begin
            if (bemf_mag < level)
                flag <= 1'b1;
            else if (bemf_mag > level)
                flag <= 1'b0;
        end
    end

    p_dis_clear_r2: assert property (@(posedge clk) disable iff (rst)
        !det_en |=> !flag);

    p_tgt_clear_r8: assert property (@(posedge clk) disable iff (rst)
        det_en && st.tgt_chg |=> !flag);

    p_set_below_r4: assert property (@(posedge clk) disable iff (rst)
        det_en && !st.tgt_chg && st.armed && bemf_vld && (bemf_mag < level) |=> flag);

    p_clr_above_r5: assert property (@(posedge clk) disable iff (rst)
        det_en && !st.tgt_chg && st.armed && bemf_vld && (bemf_mag > level) |=> !flag);

    p_hold_unarmed_r3: assert property (@(posedge clk) disable iff (rst)
        det_en && !st.tgt_chg && !st.armed |=> $stable(flag));
endmodule

// File: rtl/endstop_detect.sv
module endstop_detect
    import endstop_pkg::*;
#(
    parameter int SAMPLE_W  = 10,
    parameter int END_STEP  = 64,
    parameter int LOCK_BASE = 100,
    parameter int LOCK_INC  = 50,
    parameter int LOCK_MAX  = 400
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                det_en,
    input  logic [1:0]          target,
    input  logic [1:0]          end_lvl,
    input  logic [2:0]          lock_lvl,
    input  logic [SAMPLE_W-1:0] bemf_mag,
    input  logic                bemf_vld,
    input  logic                zc_pulse,
    output logic                stall_flag
);
    target_e             tgt;
    arm_state_t          st;
    logic [SAMPLE_W-1:0] level;

    assign tgt = target_e'(target);

    endstop_level #(
        .SAMPLE_W (SAMPLE_W),
        .END_STEP (END_STEP),
        .LOCK_BASE(LOCK_BASE),
        .LOCK_INC (LOCK_INC),
        .LOCK_MAX (LOCK_MAX)
    ) u_level (
        .clk     (clk),
        .rst     (rst),
        .target  (tgt),
        .end_lvl (end_lvl),
        .lock_lvl(lock_lvl),
        .level   (level)
    );

    endstop_arm u_arm (
        .clk     (clk),
        .rst     (rst),
        .det_en  (det_en),
        .target  (tgt),
        .zc_pulse(zc_pulse),
        .st      (st)
    );

    endstop_flag #(
        .SAMPLE_W(SAMPLE_W)
    ) u_flag (
        .clk     (clk),
        .rst     (rst),
        .det_en  (det_en),
        .st      (st),
        .bemf_vld(bemf_vld),
        .bemf_mag(bemf_mag),
        .level   (level),
        .flag    (stall_flag)
    );

    p_reset_r1: assert property (@(posedge clk) rst |=> !stall_flag);
endmodule

// File: tb/endstop_detect_tb.sv
module endstop_detect_tb;
    localparam int SW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          det_en = 1'b0;
    logic [1:0]    target = 2'b00;
    logic [1:0]    end_lvl = 2'b00;
    logic [2:0]    lock_lvl = 3'b000;
    logic [SW-1:0] bemf_mag = '0;
    logic          bemf_vld = 1'b0;
    logic          zc_pulse = 1'b0;
    logic          stall_flag;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    endstop_detect u_dut (
        .clk(clk), .rst(rst), .det_en(det_en), .target(target),
        .end_lvl(end_lvl), .lock_lvl(lock_lvl), .bemf_mag(bemf_mag),
        .bemf_vld(bemf_vld), .zc_pulse(zc_pulse), .stall_flag(stall_flag)
    );

    task automatic chk(input logic exp, input string req);
        checks++;
        if (stall_flag !== exp) begin
            failures++;
            $display("FAIL %s: stall_flag=%0b expected=%0b", req, stall_flag, exp);
        end
    endtask

    task automatic sample(input int v);
        @(negedge clk);
        bemf_mag = SW'(v);
        bemf_vld = 1'b1;
        @(negedge clk);
        bemf_vld = 1'b0;
    endtask

    task automatic arm();
        @(negedge clk);
        zc_pulse = 1'b1;
        @(negedge clk);
        zc_pulse = 1'b0;
    endtask

    task automatic set_target(input logic [1:0] t);
        @(negedge clk);
        target = t;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(1'b0, "R1 reset");
        det_en = 1'b1;
        sample(5);
        chk(1'b0, "R1 not armed after reset");
    endtask

    task automatic t_arming();
        sample(10);
        chk(1'b0, "R3 sample before zc ignored");
        arm();
        sample(10);
        chk(1'b1, "R4 below level sets");
    endtask

    task automatic t_equal_hold();
        sample(64);
        chk(1'b1, "R5 equal holds set");
        sample(65);
        chk(1'b0, "R5 above clears");
        sample(64);
        chk(1'b0, "R5 equal holds clear");
    endtask

    task automatic t_end_levels(input logic [1:0] t);
        set_target(t);
        arm();
        for (int k = 0; k < 4; k++) begin
            end_lvl = 2'(k);
            sample(64 * (k + 1) + 1);
            chk(1'b0, $sformatf("R6 tgt%0d lvl%0d above", t, k));
            sample(64 * (k + 1) - 1);
            chk(1'b1, $sformatf("R6 tgt%0d lvl%0d below", t, k));
            sample(64 * (k + 1) + 1);
            chk(1'b0, $sformatf("R6 tgt%0d lvl%0d re-clear", t, k));
        end
    endtask

    task automatic t_tray(input logic [1:0] t);
        set_target(t);
        chk(1'b0, "R8 target change clears");
        arm();
        for (int c = 0; c < 8; c++) begin
            int lv;
            lv = (c == 7) ? 400 : 100 + 50 * c;
            lock_lvl = 3'(c);
            sample(lv - 1);
            chk(1'b1, $sformatf("R7 code%0d below", c));
            sample(lv + 1);
            chk(1'b0, $sformatf("R7 code%0d above", c));
        end
        sample(380);
        chk(1'b1, "R7 saturated below");
        sample(420);
        chk(1'b0, "R7 code7 saturates at 400");
    endtask

    task automatic t_target_change();
        set_target(2'b00);
        arm();
        end_lvl = 2'b00;
        sample(3);
        chk(1'b1, "R8 setup flag");
        @(negedge clk);
        target = 2'b01;
        zc_pulse = 1'b1;
        @(negedge clk);
        zc_pulse = 1'b0;
        chk(1'b0, "R8 flag cleared by change");
        sample(3);
        chk(1'b0, "R8 zc during change does not arm");
    endtask

    task automatic t_disable();
        arm();
        sample(3);
        chk(1'b1, "R2 setup flag");
        @(negedge clk);
        det_en = 1'b0;
        @(negedge clk);
        chk(1'b0, "R2 disable clears");
        arm();
        sample(3);
        chk(1'b0, "R2 samples ignored while off");
        det_en = 1'b1;
        sample(3);
        chk(1'b0, "R2 disarmed after re-enable");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        bemf_mag = SW'(3);
        bemf_vld = 1'b1;
        zc_pulse = 1'b1;
        @(negedge clk);
        bemf_vld = 1'b0;
        zc_pulse = 1'b0;
        chk(1'b0, "R9 sample with zc not compared");
        sample(3);
        chk(1'b1, "R9 next sample compared");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_arming();
        t_equal_hold();
        t_end_levels(2'b01);
        t_end_levels(2'b00);
        t_tray(2'b10);
        t_tray(2'b11);
        t_target_change();
        t_disable();
        t_same_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule